// File: doc/BRIEF.md
# External Master Address Decoder

This block sits on the slave side of a microcontroller that an outside bus master can drive. The outside bus carries only 24 address bits. For each access the block pads the address up to the 32-bit internal width with zeros in the top byte. It then decides which internal target the access lands on. The three targets are a fixed internal address block, a small special-register window, and a set of memory-controller regions that each own a chip select.

The special-register window is reached through a one-shot arm bit in a small control register. After the arm bit is written, only the next access decodes against the window. The access after that decodes through the normal map again, so the control register stays reachable. A separate lock bit in the same register blocks window access while it is set. Any access that hits neither the first compare stage nor any region raises a no-match flag.

All target outputs are registered. They appear as a one-cycle pulse in the clock cycle after the strobe.

Top module: `xm_addr_decoder`

## Requirements
- R1: The 24-bit external address is widened to 32 bits with bits 31..24 forced to zero before every compare. A region whose base has a nonzero top byte under its mask can never match.
- R2: When the window mode is off, an address inside the internal block (addr & INT_MASK == INT_BASE & INT_MASK) selects the internal target only. No chip select is driven, even if a region also covers that address.
- R3: When the window mode is on and the address falls inside the special window, the special target is selected and every chip select stays low.
- R4: Window mode is on only for the first strobe after arming. That strobe clears the arm bit, and the next strobe with the same address decodes through the normal map.
- R5: The control register holds the arm bit at ctl_wdata bit 0 and the lock bit at bit 1. Window mode equals arm AND NOT lock. With the lock bit set, an armed access decodes exactly as an unarmed one and never selects the special target.
- R6: While window mode is on, the internal block is not compared. An armed address outside the window goes straight to the region stage, even if it lies inside the internal block.
- R7: Region i matches when (addr & mask_i) == (base_i & mask_i). When several regions match, the lowest index wins, and at most one chip select (cs bit i for region i) is high.
- R8: When no stage matches, no_match is high and sel_int, sel_spr and cs are all low.
- R9: Outputs are registered. Exactly one of {sel_int, sel_spr, any cs, no_match} is high in the cycle after a strobe, and all of them are low in every other cycle.
- R10: Reset clears the arm bit, the lock bit and all outputs.
- R11: The arm bit holds across idle cycles until a strobe consumes it. A control write overrides it, and writing arm=0 disarms it. When a write and a strobe fall in the same cycle, the strobe decodes with the old value and the written value holds afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_addr | input | EXT_AW | Address from the external bus |
| xfer_strobe | input | 1 | One-cycle access strobe |
| ctl_we | input | 1 | Control register write enable |
| ctl_wdata | input | 2 | Control write data: bit 0 arm, bit 1 lock |
| rgn_base | input | N_RGN*INT_AW | Region bases, region i at bits [i*INT_AW +: INT_AW] |
| rgn_mask | input | N_RGN*INT_AW | Region masks, same packing |
| sel_int | output | 1 | Internal block selected |
| sel_spr | output | 1 | Special window selected |
| cs | output | N_RGN | Region chip selects, one-hot or zero |
| no_match | output | 1 | No stage matched |

## Verification
The bench sweeps the top ten address bits, with varied low bits, in three modes: unarmed, armed and unlocked, and armed and locked. It does this for two region layouts, one with overlaps in both priority directions and one with a catch-all region. A decoder that skipped the one-shot clear would keep sending repeat accesses to the window. One that still compared the internal block in window mode would answer sel_int where a region or no_match is due. Directed cases cover a write in the same cycle as a strobe, an arm bit held across idle cycles, disarming, and reset in the middle of an armed state; getting any of these wrong changes which target the next strobe selects.

// File: rtl/xm_dec_pkg.sv
package xm_dec_pkg;

   localparam int CTL_ARM_BIT  = 0;
   localparam int CTL_LOCK_BIT = 1;
   localparam int CTL_W        = 2;

   typedef enum logic [2:0] {
      TGT_MISS = 3'd0,
      TGT_INT  = 3'd1,
      TGT_SPR  = 3'd2,
      TGT_RGN  = 3'd3
   } xm_target_e;

endpackage

// File: rtl/xm_ctl_reg.sv
module xm_ctl_reg
   import xm_dec_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_we,
   input  logic [CTL_W-1:0] ctl_wdata,
   input  logic             xfer_strobe,
   output logic             armed,
   output logic             locked
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed  <= 1'b0;
         locked <= 1'b0;
      end else if (ctl_we) begin
         armed  <= ctl_wdata[CTL_ARM_BIT];
         locked <= ctl_wdata[CTL_LOCK_BIT];
      end else if (xfer_strobe) begin
         armed  <= 1'b0;
      end
   end

   // R4: a strobe with no competing write consumes the arm bit
   assert_oneshot_clear_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_strobe && !ctl_we) |=> !armed);

   // R11: a write always wins over a same-cycle strobe
   assert_write_wins_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      ctl_we |=> (armed == $past(ctl_wdata[CTL_ARM_BIT])));

   // R11: arm bit holds while idle
   assert_arm_hold_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_we && !xfer_strobe) |=> $stable(armed));

endmodule

// File: rtl/xm_win_match.sv
module xm_win_match #(
   parameter int          AW   = 32,
   parameter logic [AW-1:0] BASE = '0,
   parameter logic [AW-1:0] MASK = '1
) (
   input  logic [AW-1:0] addr,
   output logic          hit
);

   localparam logic [AW-1:0] BASE_M = BASE & MASK;

   generate
      if ((BASE & ~MASK) != '0) begin : g_bad_base
         $error("xm_win_match: BASE has bits outside MASK");
      end
      if (MASK == '0) begin : g_all
         assign hit = 1'b1;
      end else begin : g_cmp
         assign hit = ((addr & MASK) == BASE_M);
      end
   endgenerate

endmodule

// File: rtl/xm_region_dec.sv
module xm_region_dec #(
   parameter int N         = 4,
   parameter int AW        = 32,
   parameter bit LOW_FIRST = 1'b1
) (
   input  logic [AW-1:0]   addr,
   input  logic [N*AW-1:0] base_flat,
   input  logic [N*AW-1:0] mask_flat,
   output logic [N-1:0]    grant
);

   logic [N-1:0] hit;

   generate
      if (N < 1) begin : g_bad_n
         $error("xm_region_dec: N must be at least 1");
      end
      for (genvar i = 0; i < N; i++) begin : g_rgn
         logic [AW-1:0] b_i;
         logic [AW-1:0] m_i;
         assign b_i    = base_flat[i*AW +: AW];
         assign m_i    = mask_flat[i*AW +: AW];
         assign hit[i] = ((addr & m_i) == (b_i & m_i));
      end

      if (LOW_FIRST) begin : g_low
         always_comb begin
            grant = '0;
            for (int k = N - 1; k >= 0; k--) begin
               if (hit[k]) grant = N'(1) << k;
            end
         end
      end else begin : g_high
         always_comb begin
            grant = '0;
            for (int k = 0; k < N; k++) begin
               if (hit[k]) grant = N'(1) << k;
            end
         end
      end
   endgenerate

   // R7: grant is one-hot or empty and only on matching regions
   always_comb begin
      assert_grant_subset_R7 : assert ($onehot0(grant) && ((grant & ~hit) == '0));
   end

endmodule

// File: rtl/xm_addr_decoder.sv
module xm_addr_decoder
   import xm_dec_pkg::*;
#(
   parameter int              EXT_AW   = 24,
   parameter int              INT_AW   = 32,
   parameter int              N_RGN    = 4,
   parameter logic [INT_AW-1:0] INT_BASE = 32'h0000_0000,
   parameter logic [INT_AW-1:0] INT_MASK = 32'hFFC0_0000,
   parameter logic [INT_AW-1:0] SPR_BASE = 32'h0038_0000,
   parameter logic [INT_AW-1:0] SPR_MASK = 32'hFFFF_C000,
   parameter bit              RGN_LOW_FIRST = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [EXT_AW-1:0]       ext_addr,
   input  logic                    xfer_strobe,
   input  logic                    ctl_we,
   input  logic [1:0]              ctl_wdata,
   input  logic [N_RGN*INT_AW-1:0] rgn_base,
   input  logic [N_RGN*INT_AW-1:0] rgn_mask,
   output logic                    sel_int,
   output logic                    sel_spr,
   output logic [N_RGN-1:0]        cs,
   output logic                    no_match
);

   localparam int PAD_W = INT_AW - EXT_AW;

   generate
      if (PAD_W < 1) begin : g_bad_width
         $error("xm_addr_decoder: INT_AW must exceed EXT_AW");
      end
      if (N_RGN < 1 || N_RGN > 32) begin : g_bad_rgn
         $error("xm_addr_decoder: N_RGN out of range");
      end
   endgenerate

   // widen: top bits forced to zero
   logic [INT_AW-1:0] addr_w;
   assign addr_w = {{PAD_W{1'b0}}, ext_addr};

   logic armed;
   logic locked;

   xm_ctl_reg u_ctl (
      .clk         (clk),
      .rst_n       (rst_n),
      .ctl_we      (ctl_we),
      .ctl_wdata   (ctl_wdata),
      .xfer_strobe (xfer_strobe),
      .armed       (armed),
      .locked      (locked)
   );

   logic int_hit;
   logic spr_hit;

   xm_win_match #(.AW(INT_AW), .BASE(INT_BASE), .MASK(INT_MASK)) u_int_win (
      .addr (addr_w),
      .hit  (int_hit)
   );

   xm_win_match #(.AW(INT_AW), .BASE(SPR_BASE), .MASK(SPR_MASK)) u_spr_win (
      .addr (addr_w),
      .hit  (spr_hit)
   );

   logic [N_RGN-1:0] rgn_grant;

   xm_region_dec #(.N(N_RGN), .AW(INT_AW), .LOW_FIRST(RGN_LOW_FIRST)) u_rgn (
      .addr      (addr_w),
      .base_flat (rgn_base),
      .mask_flat (rgn_mask),
      .grant     (rgn_grant)
   );

   logic       win_mode;
   xm_target_e tgt;

   assign win_mode = armed & ~locked;

   always_comb begin
      tgt = TGT_MISS;
      if (!win_mode && int_hit)     tgt = TGT_INT;
      else if (win_mode && spr_hit) tgt = TGT_SPR;
      else if (|rgn_grant)          tgt = TGT_RGN;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_int  <= 1'b0;
         sel_spr  <= 1'b0;
         cs       <= '0;
         no_match <= 1'b0;
      end else begin
         sel_int  <= xfer_strobe && (tgt == TGT_INT);
         sel_spr  <= xfer_strobe && (tgt == TGT_SPR);
         cs       <= (xfer_strobe && (tgt == TGT_RGN)) ? rgn_grant : '0;
         no_match <= xfer_strobe && (tgt == TGT_MISS);
      end
   end

   // R9: exactly one target the cycle after a strobe
   assert_one_target_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      $past(xfer_strobe) |-> ($countones({sel_int, sel_spr, |cs, no_match}) == 1));

   // R9: silent when no strobe preceded
   assert_idle_quiet_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      !$past(xfer_strobe) |-> (!sel_int && !sel_spr && cs == '0 && !no_match));

   // R5: special target only from an armed, unlocked state
   assert_spr_unlocked_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      sel_spr |-> $past(armed && !locked));

   // R6: internal block is never chosen while window mode is on
   assert_int_not_in_win_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      sel_int |-> !$past(armed && !locked));

   // R7: chip selects one-hot or empty
   assert_cs_onehot_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cs));

   // R4: the access that used the window leaves the decoder disarmed unless rewritten
   assert_spr_consumes_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (sel_spr && !$past(ctl_we)) |-> !armed);

endmodule

// File: tb/xm_addr_decoder_tb.sv
`timescale 1ns/1ps
module xm_addr_decoder_tb;

   localparam int N   = 4;
   localparam int EAW = 24;
   localparam int IAW = 32;
   localparam logic [31:0] INT_BASE = 32'h0000_0000;
   localparam logic [31:0] INT_MASK = 32'hFFC0_0000;
   localparam logic [31:0] SPR_BASE = 32'h0038_0000;
   localparam logic [31:0] SPR_MASK = 32'hFFFF_C000;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [EAW-1:0] ext_addr = '0;
   logic           xfer_strobe = 1'b0;
   logic           ctl_we = 1'b0;
   logic [1:0]     ctl_wdata = '0;
   logic [N*IAW-1:0] rgn_base;
   logic [N*IAW-1:0] rgn_mask;
   logic           sel_int, sel_spr, no_match;
   logic [N-1:0]   cs;

   logic [31:0] base_a [N];
   logic [31:0] mask_a [N];

   int total = 0;
   int bad   = 0;
   bit model_armed = 1'b0;
   bit model_lock  = 1'b0;

   always #2.5 clk = ~clk;

   always_comb begin
      for (int i = 0; i < N; i++) begin
         rgn_base[i*IAW +: IAW] = base_a[i];
         rgn_mask[i*IAW +: IAW] = mask_a[i];
      end
   end

   xm_addr_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr), .xfer_strobe(xfer_strobe),
      .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .rgn_base(rgn_base), .rgn_mask(rgn_mask),
      .sel_int(sel_int), .sel_spr(sel_spr), .cs(cs), .no_match(no_match)
   );

   // {sel_int, sel_spr, cs[3:0], no_match}
   function automatic logic [6:0] expect_out(input logic [23:0] a, input bit wmode);
      logic [31:0] w;
      logic [3:0]  one;
      w = {8'h00, a};
      if (!wmode && ((w & INT_MASK) == (INT_BASE & INT_MASK))) return 7'b1000000;
      if (wmode && ((w & SPR_MASK) == (SPR_BASE & SPR_MASK)))  return 7'b0100000;
      for (int i = 0; i < N; i++) begin
         if ((w & mask_a[i]) == (base_a[i] & mask_a[i])) begin
            one = 4'b0001 << i;
            return {2'b00, one, 1'b0};
         end
      end
      return 7'b0000001;
   endfunction

   function automatic logic [6:0] outs();
      return {sel_int, sel_spr, cs, no_match};
   endfunction

   task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%b exp=%b", req, act, exp);
      end
   endtask

   task automatic ctl_write(input bit arm, input bit lock);
      @(negedge clk);
      ctl_we = 1'b1;
      ctl_wdata = {lock, arm};
      @(negedge clk);
      ctl_we = 1'b0;
      model_armed = arm;
      model_lock  = lock;
   endtask

   task automatic access(input logic [23:0] a, input string req);
      logic [6:0] exp;
      @(negedge clk);
      ext_addr = a;
      xfer_strobe = 1'b1;
      exp = expect_out(a, model_armed && !model_lock);
      @(negedge clk);
      xfer_strobe = 1'b0;
      check(req, outs(), exp);
      model_armed = 1'b0;
   endtask

   task automatic access_with_write(input logic [23:0] a, input bit arm, input bit lock,
                                    input string req);
      logic [6:0] exp;
      @(negedge clk);
      ext_addr = a;
      xfer_strobe = 1'b1;
      ctl_we = 1'b1;
      ctl_wdata = {lock, arm};
      exp = expect_out(a, model_armed && !model_lock);
      @(negedge clk);
      xfer_strobe = 1'b0;
      ctl_we = 1'b0;
      check(req, outs(), exp);
      model_armed = arm;
      model_lock  = lock;
   endtask

   task automatic sweep(input string tag);
      for (int mode = 0; mode < 3; mode++) begin
         for (int hi = 0; hi < 1024; hi++) begin
            logic [13:0] lo;
            logic [23:0] a;
            lo = 14'((hi * 37 + mode * 5 + 3) & 14'h3FFF);
            a  = {hi[9:0], lo};
            if (mode == 0) begin
               if (model_lock || model_armed) ctl_write(1'b0, 1'b0);
               access(a, {tag, " R1 R2 R7 R8 unarmed"});
            end else if (mode == 1) begin
               ctl_write(1'b1, 1'b0);
               access(a, {tag, " R3 R6 R7 R8 armed"});
            end else begin
               ctl_write(1'b1, 1'b1);
               access(a, {tag, " R5 locked"});
            end
         end
      end
      ctl_write(1'b0, 1'b0);
   endtask

   initial begin
      #(150000 * 5);
      total++;
      bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // config A: overlap 0/1 (region0 wins), region3 needs top byte = 1
      base_a[0] = 32'h0040_0000; mask_a[0] = 32'hFFC0_0000;
      base_a[1] = 32'h0050_0000; mask_a[1] = 32'hFFF0_0000;
      base_a[2] = 32'h0080_0000; mask_a[2] = 32'hFF80_0000;
      base_a[3] = 32'h0100_0000; mask_a[3] = 32'hFF00_0000;

      repeat (3) @(negedge clk);
      check("R10 outputs in reset", outs(), 7'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 outputs after reset", outs(), 7'b0);

      // R10: arm clear after reset, window address goes to internal block
      access(24'h38_0010, "R10 arm clear");
      // R10: lock clear after reset, arm alone opens the window
      ctl_write(1'b1, 1'b0);
      access(24'h38_0010, "R3 window hit");
      // R4: next access with same address is normal
      access(24'h38_0010, "R4 one-shot consumed");
      @(negedge clk);
      check("R9 idle cycle quiet", outs(), 7'b0);

      // R11: arm survives idle cycles
      ctl_write(1'b1, 1'b0);
      repeat (6) @(negedge clk);
      access(24'h38_0020, "R11 arm held across idle");
      // R11: disarm by writing 0
      ctl_write(1'b1, 1'b0);
      ctl_write(1'b0, 1'b0);
      access(24'h38_0020, "R11 disarm");
      // R11: write and strobe together, old value decodes
      access_with_write(24'h38_0030, 1'b1, 1'b0, "R11 same-cycle write old value");
      access(24'h38_0030, "R11 same-cycle write takes effect");
      ctl_write(1'b1, 1'b0);
      access_with_write(24'h38_0030, 1'b1, 1'b0, "R11 strobe consumes, write rearms");
      access(24'h38_0030, "R11 rearmed window");

      // R6: armed, address in internal block but outside window -> regions/miss
      ctl_write(1'b1, 1'b0);
      access(24'h00_1000, "R6 internal block skipped in window mode");
      // R7: overlap, lowest wins
      access(24'h50_0000, "R7 lowest region wins");
      // R1: top byte zero, region3 never hits; above 8MB region2 catches
      access(24'hFF_FFFF, "R1 widened address");
      // R8: nothing
      base_a[2] = 32'h0200_0000;
      access(24'h90_0000, "R8 no match");
      base_a[2] = 32'h0080_0000;

      // R10: reset while armed and locked
      ctl_write(1'b1, 1'b1);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R10 outputs during reset", outs(), 7'b0);
      rst_n = 1'b1;
      model_armed = 1'b0;
      model_lock  = 1'b0;
      access(24'h38_0000, "R10 arm cleared by reset");

      sweep("cfgA");

      // config B: region1 wide, region0 narrower inside it, region3 catch-all
      base_a[0] = 32'h0050_0000; mask_a[0] = 32'hFFF0_0000;
      base_a[1] = 32'h0040_0000; mask_a[1] = 32'hFFE0_0000;
      base_a[2] = 32'h00C0_0000; mask_a[2] = 32'hFFC0_0000;
      base_a[3] = 32'h0000_0000; mask_a[3] = 32'h0000_0000;
      sweep("cfgB");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule